// File: doc/BRIEF.md
# Host Port Ready Handshake Controller

This block is the slave end of a 16-bit multiplexed host port. The host frames each access with an active-low chip select and an active-low data strobe. Their OR forms an internal strobe. When that strobe falls, the block captures a 2-bit port selector, the read/write line and a halfword-select line. Each access goes to one of three places: a small control register, an address register that points the internal DMA side at memory, or a data port. The data port is backed by a write queue, which the DMA side drains, and a read queue, which the DMA side fills.

The ready output holds a data-port access off while the queue behind it cannot serve it: on a write, the write queue is full; on a read, the read queue is empty. A host that raises its data strobe before ready returns still closes the access. In that case nothing is transferred and a sticky error flag records it. A host that drops chip select while its data strobe is still low abandons the access without any effect and may start a fresh one.

Top module: `host_port_ready`

## Requirements
- R1: The internal strobe is `h_cs_n | h_ds_n`. On its falling edge `h_ctl`, `h_rnw` and `h_hsel` are captured, and the whole access is routed by those captured values even if the pins change later.
- R2: Selector 2'b00 is the control register and 2'b01 the address register. 2'b10 is the data port and adds 2 to the address after each completed transfer. 2'b11 is the data port with the address left unchanged.
- R3: `h_rdy` is low only while `h_cs_n` is low and an access is open.
- R4: A data-port write holds `h_rdy` low while the write queue holds `FIFO_DEPTH` (default 8) halfwords. It goes high once the DMA side pops one.
- R5: A data-port read holds `h_rdy` low while the read queue is empty. It goes high once the DMA side pushes a halfword, and the host then reads the oldest queued halfword.
- R6: A rising `h_ds_n` while the resource is not ready still closes the access. It sets the error flag, moves no data into or out of either queue, and leaves the address unchanged. A read closed this way returns a meaningless value.
- R7: A rise of `h_cs_n` while `h_ds_n` is still low abandons the open access. It has no effect on queues, address or error flag. The next strobe fall starts a new access whose ready depends only on its own resource.
- R8: Control-register accesses ignore `h_hsel`, so both halfword positions reach the same register. Bit 0 reads the error flag (writes to it are ignored). Bit 1 is the high-half-first setting, which is readable and writable. All other bits read 0.
- R9: An address-register access reaches bits [ADDR_W-1:16] when `h_hsel ^ hi_first` is 1 and bits [15:0] otherwise. A read returns the same half that a write would change.
- R10: The error flag stays set across any number of other accesses. Any completed control-register write clears it. It appears on `err_flag` and in control bit 0.
- R11: The DMA side sees the queues in order. `wf_data` is the oldest written halfword while `wf_valid` is 1. A pop of an empty write queue is ignored. A push while `rf_ready` is 0 (read queue full) is ignored.
- R12: After reset, `h_rdy`=1, `err_flag`=0, `dma_addr`=0, both queues are empty and high-half-first is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; host pins are sampled synchronously |
| rst_n | input | 1 | Synchronous active-low reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ds_n | input | 1 | Host data strobe, active low |
| h_rnw | input | 1 | 1 = host reads, 0 = host writes |
| h_ctl | input | 2 | Port selector |
| h_hsel | input | 1 | Halfword position within a two-halfword access |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data |
| h_rdy | output | 1 | Ready; low inserts wait states |
| err_flag | output | 1 | Sticky early-termination flag |
| dma_addr | output | ADDR_W | Address register for the DMA side |
| wf_pop | input | 1 | DMA side removes the oldest write-queue entry |
| wf_data | output | 16 | Oldest write-queue entry |
| wf_valid | output | 1 | Write queue not empty |
| rf_push | input | 1 | DMA side adds a read-queue entry |
| rf_data | input | 16 | Entry to add to the read queue |
| rf_ready | output | 1 | Read queue not full |

## Verification
The bench fills the write queue to its last slot and issues one more write. A block that ignored the full state would let ready go high and take a ninth halfword, which would then appear on the DMA side. It reads from an empty queue both with a patient host and with an impatient one. Returning ready too early would hand back stale data, and dropping the early-close rule would leave the error flag clear or pop a phantom entry. It also abandons a stalled access by releasing chip select and then opens a control access at once. A design that counted the abandonment as a completion would set the flag or bump the address, and one that kept the old stall would hold ready low on a register that is always ready. Selector and halfword pins are scrambled after every strobe fall, so a design routing on live pins instead of captured ones returns the wrong register.

// File: rtl/hpr_pkg.sv
// Shared definitions for the host port ready controller.
// Assumes a 16-bit host data path.
package hpr_pkg;
    localparam int HW = 16;

    // Port selector carried on the host control pins
    typedef enum logic [1:0] {
        SEL_CTRL     = 2'b00,
        SEL_ADDR     = 2'b01,
        SEL_DATA_INC = 2'b10,
        SEL_DATA_FIX = 2'b11
    } port_sel_e;

    // Control register bit positions
    localparam int CB_ERR = 0;
    localparam int CB_HI  = 1;
endpackage

// File: rtl/hpr_fifo.sv
// Synchronous first-in first-out queue used on both sides of the data port.
// Assumes one clock domain. A push while full and a pop while empty are
// dropped. The head entry is shown combinationally.
module hpr_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write, no reset needed on the array
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(wr_ptr)));

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/hpr_strobe_decode.sv
// Host cycle framing: forms the internal strobe from chip select and data
// strobe and captures the selector, direction and halfword pins on its fall.
// On its rise it reports either a completion (data strobe released) or an
// abandonment (chip select released first). Assumes synchronous host pins.
// The cyc_* outputs show the captured fields, and the live pins during the
// cycle of the fall itself.
module hpr_strobe_decode
    import hpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       ds_n,
    input  logic       rnw,
    input  logic [1:0] ctl,
    input  logic       hsel,
    output logic       cyc_open,
    output port_sel_e  cyc_sel,
    output logic       cyc_rnw,
    output logic       cyc_hsel,
    output logic       cyc_done,
    output logic       cyc_quit
);
    logic      istrb, istrb_q, fall, rise, open_q;
    port_sel_e sel_q;
    logic      rnw_q, hsel_q;

    assign istrb = cs_n | ds_n;
    assign fall  = istrb_q & ~istrb;
    assign rise  = ~istrb_q & istrb & open_q;

    // Edge history, captured fields and open-cycle state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            istrb_q <= 1'b1;
            open_q  <= 1'b0;
            sel_q   <= SEL_CTRL;
            rnw_q   <= 1'b1;
            hsel_q  <= 1'b0;
        end else begin
            istrb_q <= istrb;
            if (fall) begin
                open_q <= 1'b1;
                sel_q  <= port_sel_e'(ctl);
                rnw_q  <= rnw;
                hsel_q <= hsel;
            end else if (rise) begin
                open_q <= 1'b0;
            end
        end
    end

    // Present the cycle fields, bypassing the capture registers on the fall
    always_comb begin
        cyc_open = fall | open_q;
        cyc_sel  = fall ? port_sel_e'(ctl) : sel_q;
        cyc_rnw  = fall ? rnw : rnw_q;
        cyc_hsel = fall ? hsel : hsel_q;
        cyc_done = rise & ds_n;
        cyc_quit = rise & ~ds_n;
    end

    assert_quit_needs_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_quit |-> cs_n);

    assert_fields_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && istrb_q == istrb && !istrb) |=> ($stable(sel_q) && $stable(rnw_q) && $stable(hsel_q)));
endmodule

// File: rtl/host_port_ready.sv
// Host port slave with ready handshake. Routes each host cycle to the
// control register, the address register or the data port. Holds ready low
// while the queue behind a data access cannot serve it. Records early-closed
// cycles in a sticky flag. Assumes ADDR_W between 17 and 32 and host pins
// synchronous to clk.
module host_port_ready #(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_cs_n,
    input  logic              h_ds_n,
    input  logic              h_rnw,
    input  logic [1:0]        h_ctl,
    input  logic              h_hsel,
    input  logic [15:0]       h_wdata,
    output logic [15:0]       h_rdata,
    output logic              h_rdy,
    output logic              err_flag,
    output logic [ADDR_W-1:0] dma_addr,
    input  logic              wf_pop,
    output logic [15:0]       wf_data,
    output logic              wf_valid,
    input  logic              rf_push,
    input  logic [15:0]       rf_data,
    output logic              rf_ready
);
    import hpr_pkg::*;

    localparam int HI_W = ADDR_W - HW;

    logic              cyc_open, cyc_rnw, cyc_hsel, cyc_done, cyc_quit;
    port_sel_e         cyc_sel;
    logic              is_data, res_busy, good_done, hi_half;
    logic              wf_full, wf_empty, rf_full, rf_empty;
    logic [HW-1:0]     rf_head, ctrl_rd;
    logic [ADDR_W-1:0] addr_q;
    logic              err_q, hi_first_q;

    hpr_strobe_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (h_cs_n),
        .ds_n     (h_ds_n),
        .rnw      (h_rnw),
        .ctl      (h_ctl),
        .hsel     (h_hsel),
        .cyc_open (cyc_open),
        .cyc_sel  (cyc_sel),
        .cyc_rnw  (cyc_rnw),
        .cyc_hsel (cyc_hsel),
        .cyc_done (cyc_done),
        .cyc_quit (cyc_quit)
    );

    // Resource readiness and the qualified completion
    always_comb begin
        is_data   = (cyc_sel == SEL_DATA_INC) || (cyc_sel == SEL_DATA_FIX);
        res_busy  = is_data & (cyc_rnw ? rf_empty : wf_full);
        h_rdy     = ~(cyc_open & ~h_cs_n & res_busy);
        good_done = cyc_done & ~res_busy;
        hi_half   = cyc_hsel ^ hi_first_q;
    end

    hpr_fifo #(.WIDTH(HW), .DEPTH(FIFO_DEPTH)) u_wfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (good_done & is_data & ~cyc_rnw),
        .wdata (h_wdata),
        .pop   (wf_pop),
        .head  (wf_data),
        .full  (wf_full),
        .empty (wf_empty)
    );

    hpr_fifo #(.WIDTH(HW), .DEPTH(FIFO_DEPTH)) u_rfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rf_push),
        .wdata (rf_data),
        .pop   (good_done & is_data & cyc_rnw),
        .head  (rf_head),
        .full  (rf_full),
        .empty (rf_empty)
    );

    assign wf_valid = ~wf_empty;
    assign rf_ready = ~rf_full;

    // Address register: halfword writes and post-transfer increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (good_done) begin
            if (cyc_sel == SEL_ADDR && !cyc_rnw) begin
                if (hi_half) addr_q[ADDR_W-1:HW] <= h_wdata[HI_W-1:0];
                else         addr_q[HW-1:0]      <= h_wdata;
            end else if (cyc_sel == SEL_DATA_INC) begin
                addr_q <= addr_q + ADDR_W'(2);
            end
        end
    end

    // Control register: half-order bit and sticky early-close flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= 1'b0;
            hi_first_q <= 1'b0;
        end else if (cyc_done && cyc_sel == SEL_CTRL && !cyc_rnw) begin
            err_q      <= 1'b0;
            hi_first_q <= h_wdata[CB_HI];
        end else if (cyc_done && res_busy) begin
            err_q <= 1'b1;
        end
    end

    // Read-data routing by the captured selector
    always_comb begin
        ctrl_rd         = '0;
        ctrl_rd[CB_ERR] = err_q;
        ctrl_rd[CB_HI]  = hi_first_q;
        unique case (cyc_sel)
            SEL_CTRL: h_rdata = ctrl_rd;
            SEL_ADDR: h_rdata = hi_half ? HW'(addr_q[ADDR_W-1:HW]) : addr_q[HW-1:0];
            default:  h_rdata = rf_head;
        endcase
    end

    assign dma_addr = addr_q;
    assign err_flag = err_q;

    assert_rdy_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        h_cs_n |-> h_rdy);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(cyc_done && cyc_sel == SEL_CTRL && !cyc_rnw)) |=> err_q);

    assert_early_close_no_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && res_busy) |=> ($stable(addr_q) && err_q));

    assert_step_by_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (good_done && cyc_sel == SEL_DATA_INC) |=> (addr_q == $past(addr_q) + ADDR_W'(2)));

    assert_abandon_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_quit |=> ($stable(addr_q) && $stable(err_q)));
endmodule

// File: tb/test_host_port_ready.sv
`timescale 1ns/1ps
module test_host_port_ready;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_cs_n = 1'b1, h_ds_n = 1'b1, h_rnw = 1'b1, h_hsel = 1'b0;
    logic [1:0]  h_ctl = 2'b00;
    logic [15:0] h_wdata = 16'h0;
    logic [15:0] h_rdata;
    logic        h_rdy, err_flag, wf_valid, rf_ready;
    logic [31:0] dma_addr;
    logic        wf_pop = 1'b0, rf_push = 1'b0;
    logic [15:0] wf_data, rf_data = 16'h0;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    host_port_ready i_host_port_ready (
        .clk(clk), .rst_n(rst_n), .h_cs_n(h_cs_n), .h_ds_n(h_ds_n),
        .h_rnw(h_rnw), .h_ctl(h_ctl), .h_hsel(h_hsel), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_rdy(h_rdy), .err_flag(err_flag),
        .dma_addr(dma_addr), .wf_pop(wf_pop), .wf_data(wf_data),
        .wf_valid(wf_valid), .rf_push(rf_push), .rf_data(rf_data),
        .rf_ready(rf_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] wq[$];
    logic [15:0] rq[$];
    logic [31:0] m_addr;
    logic        m_err, m_hi, m_prev, m_act, m_ok = 1'b0;
    logic [1:0]  m_ctl;
    logic        m_rnw, m_hsel;
    logic        s_istrb, s_fall, s_rise, s_busy, s_act, s_rw, s_hs, s_half;
    logic [1:0]  s_ctl;
    logic [15:0] s_exp;
    int          wn, rn;

    always @(negedge clk) begin
        if (!rst_n) begin
            wq.delete(); rq.delete();
            m_addr = 0; m_err = 0; m_hi = 0; m_prev = 1; m_act = 0;
            m_ctl = 0; m_rnw = 1; m_hsel = 0; m_ok = 1;
        end else if (m_ok) begin
            s_istrb = h_cs_n | h_ds_n;
            s_fall  = m_prev && !s_istrb;
            s_rise  = !m_prev && s_istrb && m_act;
            s_ctl   = s_fall ? h_ctl : m_ctl;
            s_rw    = s_fall ? h_rnw : m_rnw;
            s_hs    = s_fall ? h_hsel : m_hsel;
            s_act   = s_fall || m_act;
            s_half  = s_hs ^ m_hi;
            wn = wq.size(); rn = rq.size();
            s_busy  = s_ctl[1] && (s_rw ? (rn == 0) : (wn == DEPTH));
            chk("R3", h_rdy, !(s_act && !h_cs_n && s_busy));
            chk("R10", err_flag, m_err);
            chk("R2", dma_addr, m_addr);
            chk("R11", wf_valid, wn > 0);
            chk("R11", rf_ready, rn < DEPTH);
            if (wn > 0) chk("R11", wf_data, wq[0]);
            if (s_act && s_rw && !h_cs_n && !(s_ctl[1] && rn == 0)) begin
                case (s_ctl)
                    2'b00:   s_exp = {14'b0, m_hi, m_err};
                    2'b01:   s_exp = s_half ? m_addr[31:16] : m_addr[15:0];
                    default: s_exp = rq[0];
                endcase
                chk("R1", h_rdata, s_exp);
            end
            // state update for the coming edge
            if (wf_pop && wn > 0) void'(wq.pop_front());
            if (s_rise && h_ds_n) begin
                if (s_busy) m_err = 1;
                else begin
                    case (s_ctl)
                        2'b00: if (!s_rw) begin m_err = 0; m_hi = h_wdata[1]; end
                        2'b01: if (!s_rw) begin
                                   if (s_half) m_addr[31:16] = h_wdata;
                                   else        m_addr[15:0]  = h_wdata;
                               end
                        default: begin
                            if (s_rw) void'(rq.pop_front());
                            else      wq.push_back(h_wdata);
                            if (s_ctl == 2'b10) m_addr = m_addr + 2;
                        end
                    endcase
                end
            end
            if (rf_push && rn < DEPTH) rq.push_back(rf_data);
            if (s_fall) begin m_act = 1; m_ctl = h_ctl; m_rnw = h_rnw; m_hsel = h_hsel; end
            else if (s_rise) m_act = 0;
            m_prev = s_istrb;
        end
    end

    // ---------------- stimulus tasks ----------------
    // mode 0: wait for ready; 1: close after hold cycles; 2: abandon after hold
    task automatic host_cycle(input logic [1:0] c, input logic rw, input logic hs,
                              input logic [15:0] wd, input int mode, input int hold,
                              output logic [15:0] rd);
        @(posedge clk); #1;
        h_ctl = c; h_rnw = rw; h_hsel = hs; h_wdata = wd; h_cs_n = 1'b0;
        @(posedge clk); #1;
        h_ds_n = 1'b0;
        @(posedge clk); #1;
        h_ctl = ~c; h_rnw = ~rw; h_hsel = ~hs;   // R1: pins scrambled after capture
        if (mode == 0) begin
            for (int n = 0; ; n++) begin
                @(negedge clk);
                if (h_rdy) break;
                if (n > 2000) begin
                    errors++; checks++;
                    $display("FAIL R3: actual=ready stuck low expected=ready high");
                    break;
                end
            end
        end else begin
            repeat (hold) @(negedge clk);
        end
        rd = h_rdata;
        if (mode == 2) begin
            @(posedge clk); #1; h_cs_n = 1'b1;
            @(posedge clk); #1; h_ds_n = 1'b1;
        end else begin
            @(posedge clk); #1; h_ds_n = 1'b1;
            @(posedge clk); #1; h_cs_n = 1'b1;
        end
    endtask

    task automatic dma_push(input logic [15:0] d);
        @(posedge clk); #1; rf_push = 1'b1; rf_data = d;
        @(posedge clk); #1; rf_push = 1'b0;
    endtask

    task automatic dma_pop(output logic [15:0] d);
        @(posedge clk); #1; wf_pop = 1'b1; d = wf_data;
        @(posedge clk); #1; wf_pop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] rd, v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R12", h_rdy, 1); chk("R12", err_flag, 0); chk("R12", dma_addr, 0);
        chk("R12", wf_valid, 0); chk("R12", rf_ready, 1);

        // R9 address halves
        host_cycle(2'b01, 0, 0, 16'h1234, 0, 0, rd);
        host_cycle(2'b01, 0, 1, 16'hABCD, 0, 0, rd);
        @(negedge clk); chk("R9", dma_addr, 32'hABCD1234);
        host_cycle(2'b01, 1, 0, 0, 0, 0, rd); chk("R9", rd, 16'h1234);
        host_cycle(2'b01, 1, 1, 0, 0, 0, rd); chk("R9", rd, 16'hABCD);

        // R8 control register ignores halfword select
        host_cycle(2'b00, 0, 1, 16'h0002, 0, 0, rd);
        host_cycle(2'b00, 1, 0, 0, 0, 0, rd); chk("R8", rd, 16'h0002);
        host_cycle(2'b00, 1, 1, 0, 0, 0, rd); chk("R8", rd, 16'h0002);
        host_cycle(2'b01, 1, 0, 0, 0, 0, rd); chk("R9", rd, 16'hABCD);
        host_cycle(2'b00, 0, 0, 16'hFFFD, 0, 0, rd);
        host_cycle(2'b00, 1, 1, 0, 0, 0, rd); chk("R8", rd, 16'h0000);

        // R2 auto-increment writes filling the write queue
        host_cycle(2'b01, 0, 0, 16'h0100, 0, 0, rd);
        host_cycle(2'b01, 0, 1, 16'h0000, 0, 0, rd);
        for (int i = 0; i < DEPTH; i++) host_cycle(2'b10, 0, 0, 16'hA000 + 16'(i), 0, 0, rd);
        @(negedge clk); chk("R2", dma_addr, 32'h110); chk("R4", err_flag, 0);

        // R4 stall on full, R6 early close
        fork
            host_cycle(2'b10, 0, 0, 16'hBEEF, 1, 6, rd);
            begin repeat (5) @(negedge clk); chk("R4", h_rdy, 0); end
        join
        @(negedge clk); chk("R6", err_flag, 1); chk("R6", dma_addr, 32'h110);
        host_cycle(2'b01, 1, 0, 0, 0, 0, rd);
        @(negedge clk); chk("R10", err_flag, 1);
        host_cycle(2'b00, 0, 0, 16'h0000, 0, 0, rd);
        @(negedge clk); chk("R10", err_flag, 0);

        // R4 stall released by a DMA pop
        fork
            host_cycle(2'b10, 0, 0, 16'hC0DE, 0, 0, rd);
            begin repeat (8) @(posedge clk); dma_pop(v); chk("R11", v, 16'hA000); end
        join
        @(negedge clk); chk("R4", dma_addr, 32'h112); chk("R4", err_flag, 0);
        for (int i = 1; i < DEPTH; i++) begin dma_pop(v); chk("R11", v, 16'hA000 + 16'(i)); end
        dma_pop(v); chk("R11", v, 16'hC0DE);
        @(negedge clk); chk("R11", wf_valid, 0);
        dma_pop(v);
        host_cycle(2'b11, 0, 0, 16'h5555, 0, 0, rd);
        dma_pop(v); chk("R11", v, 16'h5555);
        @(negedge clk); chk("R2", dma_addr, 32'h112);

        // R5 read stall released by a DMA push
        fork
            host_cycle(2'b11, 1, 0, 0, 0, 0, rd);
            begin repeat (6) @(negedge clk); chk("R5", h_rdy, 0); dma_push(16'h7001); end
        join
        chk("R5", rd, 16'h7001);
        dma_push(16'h7002); dma_push(16'h7003);
        host_cycle(2'b10, 1, 0, 0, 0, 0, rd); chk("R5", rd, 16'h7002);
        host_cycle(2'b10, 1, 0, 0, 0, 0, rd); chk("R5", rd, 16'h7003);
        @(negedge clk); chk("R2", dma_addr, 32'h116);

        // R6 early close of a read from an empty queue
        host_cycle(2'b11, 1, 0, 0, 1, 5, rd);
        @(negedge clk); chk("R6", err_flag, 1); chk("R6", dma_addr, 32'h116);
        dma_push(16'h7004);
        host_cycle(2'b11, 1, 0, 0, 0, 0, rd); chk("R6", rd, 16'h7004);
        host_cycle(2'b00, 0, 0, 16'h0000, 0, 0, rd);

        // R7 abandon a stalled read, then a control access is ready at once
        host_cycle(2'b10, 1, 0, 0, 2, 5, rd);
        @(negedge clk); chk("R7", err_flag, 0); chk("R7", dma_addr, 32'h116);
        chk("R3", h_rdy, 1);
        fork
            host_cycle(2'b00, 1, 0, 0, 1, 2, rd);
            begin repeat (3) @(negedge clk); chk("R7", h_rdy, 1); end
        join
        @(negedge clk); chk("R7", err_flag, 0);

        // R11 read queue overflow dropped
        for (int i = 1; i <= DEPTH + 1; i++) begin
            dma_push(16'h8000 + 16'(i));
            if (i == DEPTH) begin @(negedge clk); chk("R11", rf_ready, 0); end
        end
        for (int i = 1; i <= DEPTH; i++) begin
            host_cycle(2'b11, 1, 0, 0, 0, 0, rd); chk("R11", rd, 16'h8000 + 16'(i));
        end
        @(negedge clk); chk("R11", rf_ready, 1);
        dma_push(16'h8101);
        host_cycle(2'b11, 1, 0, 0, 0, 0, rd); chk("R11", rd, 16'h8101);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule